// File: doc/BRIEF.md
# Key-Locked Control Register Bank

This block is a window of 1024 word-wide control and status registers, covering 4 KB of byte address space. It is reached over a single-cycle bus with a word address. Most registers simply hold what software writes. Software tools program clocks, reset lines and pin routing through these registers, but the bank itself drives none of that hardware. Each word offset belongs to one of four access classes: read-write, read-only, write-only or unmapped. An access that breaks its class is discarded and produces a one-cycle error pulse.

Writes are guarded by a two-state lock machine. The states are `ST_LOCKED` and `ST_UNLOCKED`, and reset enters `ST_LOCKED`.
- Transition `T_OPEN` moves from `ST_LOCKED` to `ST_UNLOCKED`. It fires when the low 16 bits written to the open word equal 0xDF0D.
- Transition `T_RELOCK` moves from `ST_UNLOCKED` to `ST_LOCKED`. It fires when the low 16 bits written to the relock word equal 0x767B.
- Every other write leaves the state unchanged.

Three words accept writes in either state: the scratch word, the relock word and the open word. While the bank is locked, a write to any other writable word is dropped and pulses a lock-error flag. A write that sets bit 0 of the reset-control word while the bank is unlocked raises a one-cycle system reset request. That request does not clear the bank. Only the synchronous `rst` input restores the reset values.

Top module: `keylock_regbank`

## Requirements
- R1: After `rst`, the lock-status word (word 3) reads 1 and the stored words hold their reset values. Words 0x040 to 0x042 hold 0x0001A008, word 0x043 holds 0x3F and words 0x044 to 0x046 hold 0x00014000. Words 0x05F, 0x063, 0x067 and 0x06B hold 0x00010000, and word 0x097 holds 1. Words 0x1C0 to 0x1F5 hold 0x1601, except words 0x1C2 to 0x1C8, which hold 0x601. Words 0x202 and 0x203 hold all ones. Every other word holds 0. All outputs are 0.
- R2: A write to word 1 whose low 16 bits are 0x767B locks the bank, and word 3 then reads 1. Any other value written to word 1 leaves the lock state unchanged.
- R3: A write to word 2 whose low 16 bits are 0xDF0D unlocks the bank, whatever the upper bits are, and word 3 then reads 0. Any other value written to word 2 leaves the lock state unchanged.
- R4: Word 0 accepts writes in either lock state. It stores only bit 0 of the write data and reads back with bits 31:1 as zero.
- R5: While the bank is locked, a write to a read-write or write-only word other than words 0, 1 and 2 is discarded, and `lock_err` pulses.
- R6: While the bank is unlocked, a write to a read-write or write-only word stores the full 32-bit value.
- R7: Words 1, 2, 0x183 and 0x185 are write-only. A read of one of them, or of an unmapped word, pulses `acc_err` and still returns the stored word.
- R8: Words 3, 0x043, 0x05F, 0x063, 0x067, 0x06B, 0x097, 0x14C, 0x186 and 0x188 are read-only.
  - A write to a read-only word or to an unmapped word pulses `acc_err` and changes nothing, whatever the lock state.
  - Such a write never also raises `lock_err`.
  - The read-write words are:
    - 0x000, 0x040 to 0x042, 0x044 to 0x046
    - 0x048 to 0x05E, 0x060 to 0x062, 0x064 to 0x066, 0x068 to 0x06A
    - 0x06E, 0x070, 0x071, 0x080 to 0x091, 0x093, 0x094, 0x096
    - 0x0C0, 0x0C1, 0x110 to 0x112, 0x180, 0x187
    - 0x1C0 to 0x1F5, 0x201 to 0x203, 0x20C, 0x20D, 0x240, 0x244
    - 0x280, 0x28C, 0x294, 0x298 to 0x2A4, 0x2A8, 0x2AC
    - 0x2C0 to 0x2C3, 0x2C5, 0x2C6, 0x2D0 to 0x2DD
  - Every other word is unmapped.
- R9: An unlocked write to word 0x080 with bit 0 set stores the value and pulses `sys_rst_req` for exactly one cycle. The same write while the bank is locked gives no pulse. The pulse leaves the rest of the bank unchanged.
- R10: `bus_rdata`, `acc_err`, `lock_err` and `sys_rst_req` are registered and appear in the cycle after the access. The error flags and `sys_rst_req` return to 0 after one cycle. `bus_rdata` changes only after a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| acc_err | output | 1 | One-cycle pulse on an access that breaks its class |
| lock_err | output | 1 | One-cycle pulse on a write discarded by the lock |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions check several properties on every cycle:
- A relock or open key always moves the lock state machine.
- The lock state holds when no key is written.
- Read-only words never change after reset.
- A locked write to a guarded word always pulses `lock_err`.
- `acc_err` and `lock_err` never pulse together.
- `sys_rst_req` follows only an unlocked write of bit 0 to the reset-control word.
- Read data holds between reads.

Only the bench's sweeps can show the content side. The full access-class map is checked by reading, writing and reading again every word in both lock states. The exact reset values are checked word by word, against expected values that the bench computes itself. The bench also checks that near-miss keys leave the lock state alone, and that the reset request leaves the stored words in place.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RW   = 2'd1,
        ACC_RO   = 2'd2,
        ACC_WO   = 2'd3
    } acc_e;

    localparam logic [15:0] KEY_RELOCK = 16'h767B;
    localparam logic [15:0] KEY_OPEN   = 16'hDF0D;

    localparam int W_SCRATCH  = 'h000;
    localparam int W_RELOCK   = 'h001;
    localparam int W_OPEN     = 'h002;
    localparam int W_LOCKSTAT = 'h003;
    localparam int W_RSTCTL   = 'h080;

    // Access class of one word offset
    function automatic acc_e classify(int unsigned w);
        if (w inside {W_RELOCK, W_OPEN, 'h183, 'h185})
            return ACC_WO;
        if (w inside {W_LOCKSTAT, 'h043, 'h05F, 'h063, 'h067, 'h06B,
                      'h097, 'h14C, 'h186, 'h188})
            return ACC_RO;
        if (w inside {W_SCRATCH, ['h040:'h042], ['h044:'h046], ['h048:'h05E],
                      ['h060:'h062], ['h064:'h066], ['h068:'h06A], 'h06E,
                      'h070, 'h071, ['h080:'h091], 'h093, 'h094, 'h096,
                      'h0C0, 'h0C1, ['h110:'h112], 'h180, 'h187,
                      ['h1C0:'h1F5], ['h201:'h203], 'h20C, 'h20D, 'h240,
                      'h244, 'h280, 'h28C, 'h294, ['h298:'h2A4], 'h2A8,
                      'h2AC, ['h2C0:'h2C3], 'h2C5, 'h2C6, ['h2D0:'h2DD]})
            return ACC_RW;
        return ACC_NONE;
    endfunction

    // Value a stored word takes on reset
    function automatic logic [31:0] reset_word(int unsigned w);
        if (w inside {['h040:'h042]})             return 32'h0001_A008;
        if (w == 'h043)                           return 32'h0000_003F;
        if (w inside {['h044:'h046]})             return 32'h0001_4000;
        if (w inside {'h05F, 'h063, 'h067, 'h06B}) return 32'h0001_0000;
        if (w == 'h097)                           return 32'h0000_0001;
        if (w inside {['h1C2:'h1C8]})             return 32'h0000_0601;
        if (w inside {['h1C0:'h1F5]})             return 32'h0000_1601;
        if (w inside {'h202, 'h203})              return 32'hFFFF_FFFF;
        return 32'h0;
    endfunction

endpackage

// File: rtl/keylock_fsm.sv
module keylock_fsm (
    input  logic clk,
    input  logic rst,
    input  logic relock_hit,
    input  logic open_hit,
    output logic locked
);

    typedef enum logic {ST_LOCKED, ST_UNLOCKED} lock_state_e;

    lock_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_LOCKED;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED:   if (open_hit)   state_d = ST_UNLOCKED; // T_OPEN
            ST_UNLOCKED: if (relock_hit) state_d = ST_LOCKED;   // T_RELOCK
            default:     state_d = ST_LOCKED;
        endcase
    end

    always_comb begin
        locked = (state_q == ST_LOCKED);
    end

    p_relock_r2: assert property (@(posedge clk) disable iff (rst)
        relock_hit |=> locked);

    p_open_r3: assert property (@(posedge clk) disable iff (rst)
        (open_hit && !relock_hit) |=> !locked);

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!open_hit && !relock_hit) |=> (locked == $past(locked)));

endmodule

// File: rtl/keylock_store.sv
module keylock_store
    import keylock_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_word
);

    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        localparam logic [DATA_W-1:0] RV = DATA_W'(reset_word(i));
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= RV;
            else if (wr_en && addr == ADDR_W'(i))
                mem[i] <= wr_data;
        end
        if (classify(i) == ACC_RO) begin : g_ro
            p_ro_kept_r8: assert property (@(posedge clk) disable iff (rst)
                $stable(mem[i]));
        end
    end

    assign rd_word = mem[addr];

endmodule

// File: rtl/keylock_regbank.sv
module keylock_regbank
    import keylock_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int KEY_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              acc_err,
    output logic              lock_err,
    output logic              sys_rst_req
);

    acc_e              cls;
    logic              wr, rd, locked;
    logic              is_scratch, is_relock, is_open, is_lockstat, exempt;
    logic [KEY_W-1:0]  key;
    logic              relock_hit, open_hit;
    logic              bad_wr, bad_rd, locked_wr, store_en, rst_hit;
    logic [DATA_W-1:0] store_data, rd_word;

    always_comb begin
        cls         = classify(int'(bus_addr));
        wr          = bus_valid && bus_we;
        rd          = bus_valid && !bus_we;
        is_scratch  = (bus_addr == ADDR_W'(W_SCRATCH));
        is_relock   = (bus_addr == ADDR_W'(W_RELOCK));
        is_open     = (bus_addr == ADDR_W'(W_OPEN));
        is_lockstat = (bus_addr == ADDR_W'(W_LOCKSTAT));
        exempt      = is_scratch || is_relock || is_open;
        key         = bus_wdata[KEY_W-1:0];
        relock_hit  = wr && is_relock && (key == KEY_W'(KEY_RELOCK));
        open_hit    = wr && is_open && (key == KEY_W'(KEY_OPEN));
        bad_wr      = wr && (cls == ACC_RO || cls == ACC_NONE);
        bad_rd      = rd && (cls == ACC_WO || cls == ACC_NONE);
        locked_wr   = wr && !bad_wr && !exempt && locked;
        store_en    = wr && !bad_wr && !is_relock && !is_open
                      && (is_scratch || !locked);
        store_data  = is_scratch ? {{(DATA_W-1){1'b0}}, bus_wdata[0]} : bus_wdata;
        rst_hit     = store_en && (bus_addr == ADDR_W'(W_RSTCTL)) && bus_wdata[0];
    end

    keylock_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .relock_hit (relock_hit),
        .open_hit   (open_hit),
        .locked     (locked)
    );

    keylock_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (store_en),
        .addr    (bus_addr),
        .wr_data (store_data),
        .rd_word (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata   <= '0;
            acc_err     <= 1'b0;
            lock_err    <= 1'b0;
            sys_rst_req <= 1'b0;
        end else begin
            acc_err     <= bad_wr || bad_rd;
            lock_err    <= locked_wr;
            sys_rst_req <= rst_hit;
            if (rd)
                bus_rdata <= is_lockstat ? {{(DATA_W-1){1'b0}}, locked} : rd_word;
        end
    end

    p_lockerr_r5: assert property (@(posedge clk) disable iff (rst)
        (wr && locked && !exempt && (cls == ACC_RW || cls == ACC_WO)) |=> lock_err);

    p_err_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(acc_err && lock_err));

    p_rstreq_r9: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |-> $past(wr && !locked && bus_wdata[0]
                              && bus_addr == ADDR_W'(W_RSTCTL)));

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(bus_rdata));

endmodule

// File: tb/tb_keylock_regbank.sv
`timescale 1ns/1ps
module tb_keylock_regbank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        acc_err, lock_err, sys_rst_req;

    int total = 0;
    int bad   = 0;

    logic [31:0] model [1024];
    logic        lockm;

    always #4 clk = ~clk;

    keylock_regbank dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .acc_err(acc_err), .lock_err(lock_err), .sys_rst_req(sys_rst_req)
    );

    // 0 unmapped, 1 rw, 2 ro, 3 wo
    function automatic int cls_of(int a);
        if (a == 1 || a == 2 || a == 'h183 || a == 'h185) return 3;
        case (a)
            3, 'h43, 'h5F, 'h63, 'h67, 'h6B, 'h97, 'h14C, 'h186, 'h188: return 2;
            default: ;
        endcase
        if (a == 0) return 1;
        if ((a >= 'h40 && a <= 'h46) || (a >= 'h48 && a <= 'h6A)) return 1;
        if (a == 'h6E || a == 'h70 || a == 'h71) return 1;
        if ((a >= 'h80 && a <= 'h91) || a == 'h93 || a == 'h94 || a == 'h96) return 1;
        if (a == 'hC0 || a == 'hC1 || (a >= 'h110 && a <= 'h112)) return 1;
        if (a == 'h180 || a == 'h187 || (a >= 'h1C0 && a <= 'h1F5)) return 1;
        if ((a >= 'h201 && a <= 'h203) || a == 'h20C || a == 'h20D) return 1;
        if (a == 'h240 || a == 'h244 || a == 'h280 || a == 'h28C || a == 'h294) return 1;
        if ((a >= 'h298 && a <= 'h2A4) || a == 'h2A8 || a == 'h2AC) return 1;
        if ((a >= 'h2C0 && a <= 'h2C3) || a == 'h2C5 || a == 'h2C6) return 1;
        if (a >= 'h2D0 && a <= 'h2DD) return 1;
        return 0;
    endfunction

    function automatic logic [31:0] rv_of(int a);
        int m;
        m = a - 'h1C0;
        if (a >= 'h40 && a < 'h43) return 32'h0001A008;
        if (a == 'h43) return 32'h3F;
        if (a > 'h43 && a < 'h47) return 32'h00014000;
        if (a >= 'h5F && a <= 'h6B && ((a - 'h5F) % 4 == 0)) return 32'h00010000;
        if (a == 'h97) return 32'h1;
        if (m >= 0 && m < 54) return (m >= 2 && m <= 8) ? 32'h601 : 32'h1601;
        if (a == 'h202 || a == 'h203) return 32'hFFFFFFFF;
        return 32'h0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int a = 0; a < 1024; a++) model[a] = rv_of(a);
        lockm = 1'b1;
    endtask

    task automatic do_access(logic we, int a, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = we; bus_addr = a[9:0]; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic do_write(int a, logic [31:0] d);
        int c;
        logic e_acc, e_lock, e_req;
        string tag;
        c = cls_of(a);
        e_acc = 0; e_lock = 0; e_req = 0;
        tag = "R6";
        if (c == 0 || c == 2) begin
            e_acc = 1; tag = "R8";
        end else if (a == 0) begin
            model[0] = {31'b0, d[0]}; tag = "R4";
        end else if (a == 1) begin
            if (d[15:0] == 16'h767B) lockm = 1;
            tag = "R2";
        end else if (a == 2) begin
            if (d[15:0] == 16'hDF0D) lockm = 0;
            tag = "R3";
        end else if (lockm) begin
            e_lock = 1; tag = "R5";
        end else begin
            model[a] = d;
            if (a == 'h80 && d[0]) e_req = 1;
        end
        if (a == 'h80) tag = "R9";
        do_access(1'b1, a, d);
        chk({tag, " acc_err on write"}, 32'(acc_err), 32'(e_acc));
        chk({tag, " lock_err on write"}, 32'(lock_err), 32'(e_lock));
        chk({tag, " sys_rst_req on write"}, 32'(sys_rst_req), 32'(e_req));
    endtask

    task automatic do_read(int a, string tag);
        int c;
        logic [31:0] e;
        c = cls_of(a);
        e = (a == 3) ? {31'b0, lockm} : model[a];
        do_access(1'b0, a, 32'h0);
        chk({tag, " read data"}, bus_rdata, e);
        chk("R7 acc_err on read", 32'(acc_err), 32'(c == 0 || c == 3));
    endtask

    task automatic read_sweep(string tag);
        for (int a = 0; a < 1024; a++) do_read(a, tag);
    endtask

    task automatic apply_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        apply_reset();
        // R1: reset state of outputs and every stored word
        chk("R1 rdata after reset", bus_rdata, 32'h0);
        chk("R1 acc_err after reset", 32'(acc_err), 32'h0);
        chk("R1 lock_err after reset", 32'(lock_err), 32'h0);
        chk("R1 sys_rst_req after reset", 32'(sys_rst_req), 32'h0);
        read_sweep("R1");

        // R5: locked write discarded
        do_write('h40, 32'h12345678);
        do_read('h40, "R5");
        // R3: near-miss open key ignored, then key with garbage upper bits accepted
        do_write(2, 32'h0000DF0C);
        do_read(3, "R3");
        do_write('h41, 32'hCAFEF00D);
        do_read('h41, "R3");
        do_write(2, 32'hFFFFDF0D);
        do_read(3, "R3");

        // R6/R7/R8: unlocked write sweep with pattern, then read back
        for (int a = 0; a < 1024; a++)
            do_write(a, 32'hA5000000 ^ (a * 32'h00010003));
        read_sweep("R6");

        // R4: scratch stores bit 0 only
        do_write(0, 32'hFFFFFFFE);
        do_read(0, "R4");
        do_write(0, 32'h80000003);
        do_read(0, "R4");

        // R9: soft reset request pulse, bank untouched
        do_write('h80, 32'h00000001);
        @(negedge clk);
        chk("R9 sys_rst_req one cycle", 32'(sys_rst_req), 32'h0);
        do_read('h80, "R9");
        do_read('h40, "R9");

        // R2: near-miss relock key ignored, then real key
        do_write(1, 32'h0000767A);
        do_write('h187, 32'h0BADBEEF);
        do_read('h187, "R2");
        do_write(1, 32'h0000767B);
        do_read(3, "R2");

        // R5/R8/R4/R9: locked sweep with inverted pattern
        for (int a = 0; a < 1024; a++)
            do_write(a, ~(32'hA5000000 ^ (a * 32'h00010003)));
        read_sweep("R5");

        // R10: rdata held across non-reads, flags drop after one cycle
        do_read('h41, "R10");
        do_write(3, 32'h1);
        chk("R10 rdata held after write", bus_rdata, model['h41]);
        @(negedge clk);
        chk("R10 acc_err drops", 32'(acc_err), 32'h0);
        chk("R10 rdata held idle", bus_rdata, model['h41]);
        do_write('h42, 32'h1);
        @(negedge clk);
        chk("R10 lock_err drops", 32'(lock_err), 32'h0);

        // R1: external reset restores defaults
        apply_reset();
        do_read(3, "R1");
        do_read('h40, "R1");
        do_read('h1C4, "R1");
        do_read('h1D0, "R1");
        do_read('h203, "R1");
        do_read('h80, "R1");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule